// File: doc/BRIEF.md
# Digitally Trimmed Real-Time Clock Divider

This block turns a 32,768 Hz oscillator clock-enable into a once-per-second tick and a 512 Hz square wave for frequency measurement. It also applies a signed digital trim that corrects for a crystal running fast or slow. The trim works over a repeating schedule of 64 minutes. In the first second of each of the first 2·N minutes of that schedule, where N is the 5-bit trim magnitude, the second is made shorter or longer. A positive sign shortens it by 256 oscillator cycles, which speeds the clock up. A negative sign lengthens it by 128 cycles, which slows the clock down.

The block sits beside a register file that supplies the trim sign and magnitude, a square-wave select, a static pin level and an oscillator-disable bit. It also receives a divider-reset pulse whenever software writes the seconds or the control register. Its outputs are the seconds tick, the level of a combined test/output pin and a sticky oscillator-stop flag. Software clears that flag by writing 0 to it. All logic runs on one system clock. The oscillator arrives as a one-cycle enable on that clock.

Top module: `rtc_trim_divider`

## Requirements
- R1: Out of reset, `tick_1hz` is 0, `test_pin` is 1 and `stop_flag` is 1.
- R2: Outside an adjusted second, `tick_1hz` pulses for exactly one clock after every 2^(LOW_W+HIGH_W) accepted enables. The pulse comes in the clock that follows the enable completing the second. An enable is accepted when `osc_en` is 1 while `osc_dis` and `div_rst` are both 0.
- R3: A schedule counts SEC_PER_MIN ticks per minute and 2^(CAL_W+1) minutes per cycle, starting from second 0 of minute 0 at reset. A second is adjusted only when it is second 0 of a minute whose index is below 2·`cal_mag`.
- R4: With `cal_sign` = 1, an adjusted second lasts 2^(LOW_W+HIGH_W) − 2^LOW_W accepted enables. The post stage takes one extra count when the low stage first wraps in that second.
- R5: With `cal_sign` = 0, the first 2^(LOW_W−1) accepted enables of an adjusted second are withheld from the low stage, so the second lasts 2^(LOW_W+HIGH_W) + 2^(LOW_W−1) enables.
- R6: With `cal_mag` = 0 no second is adjusted. With `cal_mag` = 31, minutes 0 to 61 are adjusted and minutes 62 and 63 are not.
- R7: With `sq_sel` = 1, `test_pin` is registered from the top bit of an FT_W-bit counter of accepted enables. The trim never alters that counter, so the pin toggles every 2^(FT_W−1) enables.
- R8: With `sq_sel` = 0, `test_pin` equals `static_level` one clock later.
- R9: A `div_rst` pulse clears the low stage, the post stage, the withholding state and the square-wave counter, and it discards an enable in the same clock. The schedule position is kept.
- R10: While `osc_dis` is 1, no enable is accepted and no tick appears.
- R11: `stop_flag` becomes 1 one clock after `osc_dis` rises. It also becomes 1 after STALL_CYCLES consecutive clocks with `osc_en` at 0 while `osc_dis` is 0.
- R12: A write (`flag_we` = 1) with `flag_wdata` = 0 clears `stop_flag`, and a write with 1 leaves it unchanged. A set event in the same clock as a clearing write leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock pulse per oscillator cycle |
| osc_dis | input | 1 | Oscillator-disable bit; stops all counting |
| div_rst | input | 1 | Divider reset pulse (seconds or control write) |
| cal_sign | input | 1 | Trim sign: 1 speeds up, 0 slows down |
| cal_mag | input | CAL_W | Trim magnitude N |
| sq_sel | input | 1 | 1 selects the square wave on the pin |
| static_level | input | 1 | Pin level when the square wave is off |
| flag_we | input | 1 | Write strobe for the stop flag |
| flag_wdata | input | 1 | Data written to the stop flag |
| tick_1hz | output | 1 | One-clock pulse per second |
| test_pin | output | 1 | Square wave or static level |
| stop_flag | output | 1 | Sticky oscillator-stop flag |

## Verification
The stop flag has a set path and a clear path, and both can act in the same clock. The bench provokes this by raising `osc_dis` in the very clock in which it writes 0 to the flag. It then expects the flag to read 1, because the set takes priority. The bench also pulses `div_rst` at several offsets against the alternating enable pattern. Some of those pulses coincide with an enable and some do not, so the reset is seen both discarding an enable and clearing the withholding state partway through an adjusted second. A behavioural model in the bench counts enables against a per-second target and judges every clock.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

    // Kind of correction applied to the current second
    typedef enum logic [1:0] {
        ADJ_NONE   = 2'd0,
        ADJ_BLANK  = 2'd1,
        ADJ_INSERT = 2'd2
    } adj_mode_e;

endpackage

// File: rtl/rtc_trim_sched.sv
// Seconds-in-minute and minute-in-cycle counters; decides whether the
// current second is one that receives a trim.
module rtc_trim_sched
    import rtc_trim_pkg::*;
#(
    parameter int CAL_W       = 5,
    parameter int SEC_PER_MIN = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_wrap_i,
    input  logic             cal_sign_i,
    input  logic [CAL_W-1:0] cal_mag_i,
    output adj_mode_e        adj_mode_o
);
    localparam int MIN_W = CAL_W + 1;
    localparam int SEC_W = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] mins;
    } sched_t;

    sched_t st_d, st_q;
    logic   in_window;

    always_comb begin
        st_d = st_q;
        if (sec_wrap_i) begin
            if (st_q.sec == SEC_LAST) begin
                st_d.sec  = '0;
                st_d.mins = st_q.mins + 1'b1;
            end else begin
                st_d.sec = st_q.sec + 1'b1;
            end
        end
        // 2*N minutes are trimmed: compare against the magnitude shifted left
        in_window = (st_q.sec == '0) && (st_q.mins < {cal_mag_i, 1'b0});
        if (!in_window)      adj_mode_o = ADJ_NONE;
        else if (cal_sign_i) adj_mode_o = ADJ_INSERT;
        else                 adj_mode_o = ADJ_BLANK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rtc_trim_prescale.sv
// Low divider stage with enable withholding, plus the untrimmed
// square-wave counter.
module rtc_trim_prescale #(
    parameter int LOW_W = 8,
    parameter int FT_W  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic blank_req_i,
    input  logic sec_wrap_i,
    output logic low_wrap_o,
    output logic sq_level_o
);
    localparam int BLANK_N = 2 ** (LOW_W - 1);
    localparam logic [LOW_W-1:0] BLANK_LIM = LOW_W'(BLANK_N);

    typedef struct packed {
        logic [LOW_W-1:0] low;
        logic [LOW_W-1:0] blank;
        logic [FT_W-1:0]  sq;
    } pre_t;

    pre_t st_d, st_q;
    logic withhold;
    logic low_adv;

    always_comb begin
        st_d       = st_q;
        withhold   = blank_req_i && (st_q.blank < BLANK_LIM);
        low_adv    = step_i && !withhold;
        low_wrap_o = low_adv && (st_q.low == '1);
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (step_i)             st_d.sq    = st_q.sq + 1'b1;
            if (step_i && withhold) st_d.blank = st_q.blank + 1'b1;
            if (low_adv)            st_d.low   = st_q.low + 1'b1;
            if (sec_wrap_i)         st_d.blank = '0;
        end
        sq_level_o = st_q.sq[FT_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rtc_trim_post.sv
// Post stage that counts low-stage wraps into seconds; an insertion
// makes it step by two once in the trimmed second. HIGH_W must be >= 2.
module rtc_trim_post #(
    parameter int HIGH_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic low_wrap_i,
    input  logic ins_req_i,
    output logic sec_wrap_o,
    output logic tick_o
);
    typedef struct packed {
        logic [HIGH_W-1:0] high;
        logic              used;
        logic              tick;
    } post_t;

    post_t st_d, st_q;
    logic  do_ins;

    always_comb begin
        st_d       = st_q;
        do_ins     = low_wrap_i && ins_req_i && !st_q.used && (st_q.high == '0);
        sec_wrap_o = low_wrap_i && (st_q.high == '1);
        st_d.tick  = sec_wrap_o;
        if (clr_i) begin
            st_d.high = '0;
            st_d.used = 1'b0;
        end else if (low_wrap_i) begin
            if (do_ins) begin
                st_d.high = HIGH_W'(2);
                st_d.used = 1'b1;
            end else begin
                st_d.high = st_q.high + 1'b1;
            end
            if (sec_wrap_o) st_d.used = 1'b0;
        end
        tick_o = st_q.tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rtc_trim_stopflag.sv
// Sticky oscillator-stop flag: set on a disable edge or a stalled
// oscillator, cleared only by writing 0.
module rtc_trim_stopflag #(
    parameter int STALL_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en_i,
    input  logic osc_dis_i,
    input  logic flag_we_i,
    input  logic flag_wdata_i,
    output logic flag_o
);
    localparam int ST_W = $clog2(STALL_CYCLES + 1);
    localparam logic [ST_W-1:0] ST_LAST = ST_W'(STALL_CYCLES - 1);
    localparam logic [ST_W-1:0] ST_MAX  = ST_W'(STALL_CYCLES);

    typedef struct packed {
        logic [ST_W-1:0] idle;
        logic            dis_prev;
        logic            flag;
    } flag_t;

    flag_t st_d, st_q;
    logic  set_ev;

    always_comb begin
        st_d          = st_q;
        set_ev        = osc_dis_i && !st_q.dis_prev;
        st_d.dis_prev = osc_dis_i;
        if (osc_dis_i || osc_en_i) begin
            st_d.idle = '0;
        end else if (st_q.idle < ST_MAX) begin
            st_d.idle = st_q.idle + 1'b1;
            if (st_q.idle == ST_LAST) set_ev = 1'b1;
        end
        if (set_ev)                         st_d.flag = 1'b1;
        else if (flag_we_i && !flag_wdata_i) st_d.flag = 1'b0;
        flag_o = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
    import rtc_trim_pkg::*;
#(
    parameter int LOW_W        = 8,
    parameter int HIGH_W       = 7,
    parameter int FT_W         = 6,
    parameter int CAL_W        = 5,
    parameter int SEC_PER_MIN  = 60,
    parameter int STALL_CYCLES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             osc_dis,
    input  logic             div_rst,
    input  logic             cal_sign,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             sq_sel,
    input  logic             static_level,
    input  logic             flag_we,
    input  logic             flag_wdata,
    output logic             tick_1hz,
    output logic             test_pin,
    output logic             stop_flag
);
    typedef struct packed {
        logic pin;
    } top_t;

    top_t      st_d, st_q;
    logic      step;
    logic      low_wrap;
    logic      sec_wrap;
    logic      sq_level;
    adj_mode_e adj_mode;

    assign step = osc_en && !osc_dis && !div_rst;

    rtc_trim_sched #(
        .CAL_W       (CAL_W),
        .SEC_PER_MIN (SEC_PER_MIN)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_wrap_i (sec_wrap),
        .cal_sign_i (cal_sign),
        .cal_mag_i  (cal_mag),
        .adj_mode_o (adj_mode)
    );

    rtc_trim_prescale #(
        .LOW_W (LOW_W),
        .FT_W  (FT_W)
    ) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (div_rst),
        .step_i      (step),
        .blank_req_i (adj_mode == ADJ_BLANK),
        .sec_wrap_i  (sec_wrap),
        .low_wrap_o  (low_wrap),
        .sq_level_o  (sq_level)
    );

    rtc_trim_post #(
        .HIGH_W (HIGH_W)
    ) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (div_rst),
        .low_wrap_i (low_wrap),
        .ins_req_i  (adj_mode == ADJ_INSERT),
        .sec_wrap_o (sec_wrap),
        .tick_o     (tick_1hz)
    );

    rtc_trim_stopflag #(
        .STALL_CYCLES (STALL_CYCLES)
    ) u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_en_i     (osc_en),
        .osc_dis_i    (osc_dis),
        .flag_we_i    (flag_we),
        .flag_wdata_i (flag_wdata),
        .flag_o       (stop_flag)
    );

    always_comb begin
        st_d.pin = sq_sel ? sq_level : static_level;
        test_pin = st_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pin <= 1'b1;
        else        st_q     <= st_d;
    end

endmodule

// File: rtl/rtc_trim_divider_chk.sv
module rtc_trim_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic osc_dis,
    input logic div_rst,
    input logic sq_sel,
    input logic static_level,
    input logic flag_we,
    input logic flag_wdata,
    input logic tick_1hz,
    input logic test_pin,
    input logic stop_flag
);
    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz |=> !tick_1hz); // R2
    AST_RST_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> !tick_1hz); // R9
    AST_DIS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        osc_dis |=> !tick_1hz); // R10
    AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_sel |=> (test_pin == $past(static_level))); // R8
    AST_DIS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_dis) |=> stop_flag); // R11
    AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_flag) |-> $past(flag_we && !flag_wdata)); // R12
endmodule

bind rtc_trim_divider rtc_trim_divider_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_dis      (osc_dis),
    .div_rst      (div_rst),
    .sq_sel       (sq_sel),
    .static_level (static_level),
    .flag_we      (flag_we),
    .flag_wdata   (flag_wdata),
    .tick_1hz     (tick_1hz),
    .test_pin     (test_pin),
    .stop_flag    (stop_flag)
);

// File: tb/rtc_trim_divider_tb.sv
`timescale 1ns/1ps
module rtc_trim_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_W      = 3;
    localparam int HIGH_W     = 3;
    localparam int FT_W       = 3;
    localparam int CAL_W      = 5;
    localparam int SPM        = 4;
    localparam int STALL      = 40;
    localparam int L          = 2 ** LOW_W;
    localparam int S          = 2 ** (LOW_W + HIGH_W);
    localparam int FTMOD      = 2 ** FT_W;
    localparam int MINS       = 2 ** (CAL_W + 1);

    logic clk = 0, rst_n = 0;
    logic osc_en = 0, osc_dis = 0, div_rst = 0, cal_sign = 0;
    logic [CAL_W-1:0] cal_mag = '0;
    logic sq_sel = 0, static_level = 1, flag_we = 0, flag_wdata = 0;
    logic tick_1hz, test_pin, stop_flag;

    int checks = 0, errors = 0, cycles = 0, ticks_seen = 0;
    bit en_run = 1, started = 0, done = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_sec, m_min, m_ft, m_idle, tgt;
    bit m_tick, m_pin, m_flag, m_dis, setev, adj;

    rtc_trim_divider #(
        .LOW_W(LOW_W), .HIGH_W(HIGH_W), .FT_W(FT_W), .CAL_W(CAL_W),
        .SEC_PER_MIN(SPM), .STALL_CYCLES(STALL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .osc_dis(osc_dis),
        .div_rst(div_rst), .cal_sign(cal_sign), .cal_mag(cal_mag),
        .sq_sel(sq_sel), .static_level(static_level), .flag_we(flag_we),
        .flag_wdata(flag_wdata), .tick_1hz(tick_1hz), .test_pin(test_pin),
        .stop_flag(stop_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // oscillator enable: every other clock while running
    always @(negedge clk) begin
        if (!rst_n || !en_run) osc_en <= 1'b0;
        else                   osc_en <= ~osc_en;
    end

    // behavioural reference: enables counted against a per-second target
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_ft = 0; m_idle = 0;
            m_tick = 0; m_pin = 1; m_flag = 1; m_dis = 0;
        end else begin
            m_pin  = sq_sel ? m_ft[FT_W-1] : static_level;
            m_tick = 0;
            setev  = osc_dis && !m_dis;
            if (osc_dis || osc_en) m_idle = 0;
            else if (m_idle < STALL) begin
                m_idle = m_idle + 1;
                if (m_idle == STALL) setev = 1;
            end
            m_dis = osc_dis;
            if (setev) m_flag = 1;
            else if (flag_we && !flag_wdata) m_flag = 0;
            if (div_rst) begin
                m_cnt = 0; m_ft = 0;
            end else if (osc_en && !osc_dis) begin
                m_ft  = (m_ft + 1) % FTMOD;
                m_cnt = m_cnt + 1;
                adj   = (m_sec == 0) && (m_min < 2 * int'(cal_mag));
                tgt   = !adj ? S : (cal_sign ? S - L : S + L / 2);
                if (m_cnt >= tgt) begin
                    m_cnt = 0; m_tick = 1; m_sec = m_sec + 1;
                    if (m_sec == SPM) begin
                        m_sec = 0; m_min = (m_min + 1) % MINS;
                    end
                end
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            chk("tick_1hz", tick_1hz, m_tick);
            chk("test_pin", test_pin, m_pin);
            chk("stop_flag", stop_flag, m_flag);
            if (tick_1hz) ticks_seen = ticks_seen + 1;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit sgn, input int n);
        @(negedge clk);
        cal_sign = sgn; cal_mag = CAL_W'(n); div_rst = 1;
        @(negedge clk);
        div_rst = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=%0d expected<190000", cycles);
        finish_run();
    end

    initial begin
        int t0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        started = 1;
        // R1: reset state
        cur_req = "R1";
        chk("reset tick", tick_1hz, 0);
        chk("reset pin", test_pin, 1);
        chk("reset flag", stop_flag, 1);
        // R8: static level follows one clock later
        cur_req = "R8";
        static_level = 0; run(2);
        chk("pin low", test_pin, 0);
        static_level = 1; run(2);
        chk("pin high", test_pin, 1);
        // R4: insertion from minute 0, N=1
        cur_req = "R4";
        cfg(1, 1); run(2 * SPM * 2 * S);
        // R2: untrimmed seconds, count ticks over a known window
        cur_req = "R2";
        cfg(0, 0);
        t0 = ticks_seen;
        run(3 * 2 * S + 4);
        chk("ticks in 3 s", ticks_seen - t0, 3);
        // R5: withholding, N=3
        cur_req = "R5";
        cfg(0, 3); run(8 * SPM * 2 * S);
        // R3: full 64-minute schedule, N=4 slow
        cur_req = "R3";
        cfg(0, 4); run(MINS * SPM * 2 * S);
        // R6: N=31 fast over a full cycle, then N=0
        cur_req = "R6";
        cfg(1, 31); run(MINS * SPM * 2 * S);
        cfg(1, 0); run(2 * SPM * 2 * S);
        // R7: square wave, trim change does not disturb it
        cur_req = "R7";
        sq_sel = 1; run(300);
        cfg(0, 5); run(600);
        sq_sel = 0;
        // R9: divider resets at varied offsets, some on an enable
        cur_req = "R9";
        for (int k = 0; k < 6; k++) begin
            run(17 + k);
            div_rst = 1; @(negedge clk); div_rst = 0;
        end
        run(3 * S);
        // R10: disable freezes everything
        cur_req = "R10";
        osc_dis = 1;
        t0 = ticks_seen;
        run(4 * S);
        chk("ticks while disabled", ticks_seen - t0, 0);
        osc_dis = 0;
        run(5);
        // R12: clear by writing 0, writing 1 has no effect, set wins
        cur_req = "R12";
        flag_we = 1; flag_wdata = 0; @(negedge clk); flag_we = 0;
        chk("flag after clear", stop_flag, 0);
        flag_we = 1; flag_wdata = 1; @(negedge clk); flag_we = 0;
        chk("flag after write 1", stop_flag, 0);
        osc_dis = 1; flag_we = 1; flag_wdata = 0; @(negedge clk); flag_we = 0;
        chk("flag set beats clear", stop_flag, 1);
        osc_dis = 0; run(3);
        flag_we = 1; flag_wdata = 0; @(negedge clk); flag_we = 0;
        run(2);
        // R11: oscillator stall sets the flag
        cur_req = "R11";
        en_run = 0;
        run(STALL + 5);
        chk("flag after stall", stop_flag, 1);
        en_run = 1;
        run(200);
        finish_run();
    end
endmodule